// File: doc/BRIEF.md
# Prefetch Memory Controller

The controller sits between a processor core and an external byte-wide memory. It keeps its own copy of the instruction address, called the slave program counter. The core therefore never has to send a fetch address, except when it takes a jump. While the bus would otherwise be idle, the controller reads the next instruction bytes into a small queue. The core then takes bytes from the head of that queue whenever it decodes.

The core can also ask for single-byte data reads and writes, and these go ahead of any prefetch. Jump targets are computed by the core's arithmetic unit. The core hands a target to the controller with a one-cycle load strobe. The controller then empties the queue, throws away any fetch that is still on the bus, and restarts fetching at the target.

The memory side uses one request at a time with a request/acknowledge handshake. The address is 16 bits wide and the data is 8 bits wide.

Top module: `prefetch_memctl`

## Requirements
- R1: While reset is held, `ib_valid` and `mreq` are low. The first cycle after reset starts an instruction read at address 0000h with `mwe` low. Low addresses such as 0000h–00FFh are fetched over the external bus like any others.
- R2: Instruction bytes reach `ib_byte` in strictly increasing address order. The slave PC steps by one per completed fetch and wraps from FFFFh to 0000h.
- R3: The queue holds at most 4 bytes. `ib_byte` always shows the oldest byte, and a byte leaves the queue in a cycle with `ib_take` and `ib_valid` both high.
- R4: When the queue holds 4 bytes and no data access is pending, no request is started. Fetching starts again once a byte has been taken.
- R5: A cycle with `jmp_load` high empties the queue, so `ib_valid` is low in the next cycle. The next instruction fetch uses `jmp_target`, and the first byte delivered afterwards is the byte at the target.
- R6: A fetch still waiting for `mack` when `jmp_load` arrives is completed on the bus, but its byte is discarded. It never reaches `ib_byte`.
- R7: When the bus is idle and `dreq` is high, the data access is started ahead of any prefetch. A data request therefore waits for at most one in-flight fetch.
- R8: A data access puts `daddr`, `dwe` and `dwdata` on `maddr`, `mwe` and `mwdata`. `dack` is high exactly in the cycle of the memory acknowledge, and `drdata` then carries the read byte.
- R9: Once `mreq` is high, it stays high with `maddr`, `mwe` and `mwdata` unchanged until the cycle in which `mack` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jmp_load | input | 1 | One-cycle strobe: load the jump target and flush the queue |
| jmp_target | input | 16 | New instruction address |
| ib_valid | output | 1 | Queue holds at least one byte |
| ib_byte | output | 8 | Oldest queued instruction byte |
| ib_take | input | 1 | Core consumes the head byte |
| dreq | input | 1 | Data access request, held until `dack` |
| dwe | input | 1 | 1 = write, 0 = read |
| daddr | input | 16 | Data address |
| dwdata | input | 8 | Write data |
| dack | output | 1 | Data access complete |
| drdata | output | 8 | Read data, valid with `dack` |
| mreq | output | 1 | External request |
| mwe | output | 1 | External write enable |
| maddr | output | 16 | External address |
| mwdata | output | 8 | External write data |
| mack | input | 1 | External acknowledge |
| mrdata | input | 8 | External read data |

## Verification
The bench targets four corner cases:
- A jump that lands while a fetch is still waiting on slow memory. A controller that keeps that byte would hand the core one stale byte ahead of the target stream.
- A jump issued on a full, idle queue, followed by a count of the bus reads. A wrong queue limit shows up as three or five reads instead of four, and a missing flush shows the old head byte.
- Data requests made during constant prefetching. A controller that let fetches win would delay `dack` past more than one fetch acknowledge.
- A jump to FFFEh, which checks that the slave PC rolls over to 0000h rather than stalling or skipping.

// File: rtl/prefetch_memctl.sv
module prefetch_memctl #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          jmp_load,
  input  logic [AW-1:0] jmp_target,
  output logic          ib_valid,
  output logic [DW-1:0] ib_byte,
  input  logic          ib_take,
  input  logic          dreq,
  input  logic          dwe,
  input  logic [AW-1:0] daddr,
  input  logic [DW-1:0] dwdata,
  output logic          dack,
  output logic [DW-1:0] drdata,
  output logic          mreq,
  output logic          mwe,
  output logic [AW-1:0] maddr,
  output logic [DW-1:0] mwdata,
  input  logic          mack,
  input  logic [DW-1:0] mrdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] q_mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] q_cnt;
  logic [AW-1:0] spc;
  logic          busy, is_data, drop;
  logic [AW-1:0] a_r;
  logic          we_r;
  logic [DW-1:0] wd_r;

  wire done        = busy & mack;
  wire fetch_done  = done & ~is_data;
  wire push        = fetch_done & ~drop & ~jmp_load;
  wire pop         = ib_take & (q_cnt != '0) & ~jmp_load;
  wire start_data  = ~busy & dreq;
  wire start_fetch = ~busy & ~dreq & ~jmp_load & (q_cnt < CW'(DEPTH));

  assign mreq     = busy;
  assign maddr    = a_r;
  assign mwe      = we_r;
  assign mwdata   = wd_r;
  assign dack     = done & is_data;
  assign drdata   = mrdata;
  assign ib_valid = (q_cnt != '0);
  assign ib_byte  = q_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_data <= 1'b0;
      a_r     <= '0;
      we_r    <= 1'b0;
      wd_r    <= '0;
    end else if (done) begin
      busy <= 1'b0;
      we_r <= 1'b0;
    end else if (start_data) begin
      busy    <= 1'b1;
      is_data <= 1'b1;
      a_r     <= daddr;
      we_r    <= dwe;
      wd_r    <= dwdata;
    end else if (start_fetch) begin
      busy    <= 1'b1;
      is_data <= 1'b0;
      a_r     <= spc;
      we_r    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        spc <= '0;
    else if (jmp_load)                 spc <= jmp_target;
    else if (fetch_done && !drop)      spc <= spc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                      drop <= 1'b0;
    else if (jmp_load && busy && !is_data && !mack)  drop <= 1'b1;
    else if (done)                                   drop <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || jmp_load) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      q_cnt  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      q_cnt <= q_cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) q_mem[wr_ptr] <= mrdata;
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mreq && !mack |=> mreq && $stable(maddr) && $stable(mwe) && $stable(mwdata)); // R9
  AST_QUEUE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(DEPTH)); // R3
  AST_JUMP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_load |=> !ib_valid); // R5
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !mreq && dreq |=> mreq && mwe == $past(dwe) && maddr == $past(daddr)); // R7
  AST_FULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt == CW'(DEPTH) && !mreq && !dreq |=> !mreq); // R4
  AST_DACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> mreq && mack && !$past(dack)); // R8
endmodule

// File: tb/test_prefetch_memctl.sv
`timescale 1ns/1ps
module test_prefetch_memctl;
  logic clk = 0, rst_n = 0;
  logic jmp_load = 0; logic [15:0] jmp_target = '0;
  logic ib_valid, ib_take = 0; logic [7:0] ib_byte;
  logic dreq = 0, dwe = 0; logic [15:0] daddr = '0; logic [7:0] dwdata = '0;
  logic dack; logic [7:0] drdata;
  logic mreq, mwe, mack = 0; logic [15:0] maddr; logic [7:0] mwdata, mrdata = '0;

  int tests = 0, fails = 0;
  int lat = 1, wcnt = 0, ack_cnt = 0;
  logic [15:0] held;
  logic [7:0] wmem [logic [15:0]];
  logic [7:0] exp_q [$];
  logic [15:0] gen_pc = 16'h0000;
  bit take_en = 0, jump_pend = 0;
  logic [15:0] jt;
  string cur_req = "R2";

  always #2 clk = ~clk;

  prefetch_memctl i_prefetch_memctl (.clk(clk), .rst_n(rst_n), .jmp_load(jmp_load), .jmp_target(jmp_target),
    .ib_valid(ib_valid), .ib_byte(ib_byte), .ib_take(ib_take), .dreq(dreq), .dwe(dwe), .daddr(daddr),
    .dwdata(dwdata), .dack(dack), .drdata(drdata), .mreq(mreq), .mwe(mwe), .maddr(maddr),
    .mwdata(mwdata), .mack(mack), .mrdata(mrdata));

  function automatic logic [7:0] pat(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model
  always @(negedge clk) begin
    if (!rst_n) begin
      mack <= 0; wcnt = 0;
    end else if (mack) mack <= 0;
    else if (mreq) begin
      if (wcnt == 0) held = maddr;
      if (wcnt >= lat) begin
        check(maddr == held, "R9", "address held until ack", maddr, held);
        mack <= 1; wcnt = 0; ack_cnt++;
        if (mwe) wmem[maddr] = mwdata;
        else mrdata <= wmem.exists(maddr) ? wmem[maddr] : pat(maddr);
      end else wcnt++;
    end
  end

  // driver of expected stream + monitor of consumed bytes
  always @(negedge clk) begin
    #1;
    if (jump_pend) begin
      jmp_load = 1; jmp_target = jt; ib_take = 0;
      exp_q.delete(); gen_pc = jt; jump_pend = 0;
    end else begin
      jmp_load = 0;
      ib_take = take_en && ($urandom % 4 != 0);
      if (ib_take && ib_valid) begin
        logic [7:0] e;
        if (exp_q.size() == 0) e = 8'hxx; else e = exp_q.pop_front();
        check(ib_byte === e, cur_req, "fetched byte", ib_byte, e);
      end
    end
    while (exp_q.size() < 8) begin exp_q.push_back(pat(gen_pc)); gen_pc++; end
  end

  task automatic do_jump(logic [15:0] t);
    jt = t; jump_pend = 1;
    while (jump_pend) @(negedge clk);
  endtask

  task automatic data_op(bit we, logic [15:0] a, logic [7:0] wd, logic [7:0] exp_rd);
    int a0, n;
    @(negedge clk); #1;
    dreq = 1; dwe = we; daddr = a; dwdata = wd; a0 = ack_cnt; n = 0;
    do begin @(negedge clk); #1; n++; end while (!dack && n < 50);
    check(dack, "R8", "dack seen", dack, 1);
    check(ack_cnt - a0 <= 2, "R7", "acks before data done", ack_cnt - a0, 2);
    if (!we) check(drdata == exp_rd, "R8", "read data", drdata, exp_rd);
    dreq = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a0, n;
    repeat (3) @(negedge clk);
    #1;
    check(!ib_valid, "R1", "ib_valid in reset", ib_valid, 0);
    check(!mreq, "R1", "mreq in reset", mreq, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(mreq && !mwe && maddr == 16'h0000, "R1", "first fetch address", maddr, 0);

    cur_req = "R2"; take_en = 1; lat = 1;
    repeat (60) @(negedge clk);

    data_op(1, 16'h9000, 8'hA5, 8'h00);
    check(wmem.exists(16'h9000) && wmem[16'h9000] == 8'hA5, "R8", "write landed",
          wmem.exists(16'h9000) ? wmem[16'h9000] : 0, 8'hA5);
    data_op(0, 16'h9000, 8'h00, 8'hA5);
    data_op(0, 16'h9100, 8'h00, pat(16'h9100));
    repeat (20) @(negedge clk);

    cur_req = "R3"; take_en = 0;
    repeat (40) @(negedge clk);
    #1;
    check(!mreq, "R4", "no request when full", mreq, 0);
    a0 = ack_cnt;
    do_jump(16'h1230);
    repeat (40) @(negedge clk);
    #1;
    check(ack_cnt - a0 == 4, "R3", "reads to fill queue", ack_cnt - a0, 4);
    check(ib_valid && ib_byte == pat(16'h1230), "R5", "head after jump", ib_byte, pat(16'h1230));
    check(!mreq, "R4", "idle when refilled", mreq, 0);
    take_en = 1; n = 0;
    do begin @(negedge clk); #1; n++; end while (!mreq && n < 10);
    check(mreq, "R4", "fetch resumes after take", mreq, 1);
    repeat (40) @(negedge clk);

    cur_req = "R6"; lat = 3; n = 0;
    do begin @(negedge clk); #1; n++; end while (!(mreq && !mwe && !mack) && n < 50);
    do_jump(16'h4560);
    repeat (80) @(negedge clk);

    cur_req = "R2"; lat = 0;
    do_jump(16'hFFFE);
    repeat (50) @(negedge clk);
    take_en = 0;
    repeat (5) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule